// File: doc/BRIEF.md
# Quadrature Decoder with Position Counter

This block takes the two phase-shifted channel signals of an incremental encoder and turns them into a signed motion count. Each channel first crosses into the clock domain through a flop synchroniser. A small filter then passes a new level only after two equal consecutive samples. A phase decoder compares the filtered pair with its previous value and classifies each change as one step forward, one step back, no change or an illegal jump.

Each legal step moves a position register by one. Every step produces a single-clock event pulse. A direction level, which changes a clock before that pulse, says which way the step went. When the register passes through its end value, a single-clock wrap pulse accompanies the event pulse. A further counter stage downstream can therefore extend the range by counting wrap pulses and using the direction level.

The counting width is a parameter, normally 16 bits or a 12-bit variant. In the narrow variant the bits above the counting width read as zero. The active-low reset clears everything without waiting for a clock. The block leaves reset synchronously, two clocks after the reset input goes high.

Top module: `qdec_top`

## Requirements
- R1: A level change on either channel is passed to the decoder only after two consecutive equal synchronised samples. A change that lasts a single clock produces no count and no pulse.
- R2: With the state written as {A,B}, the sequence 00→01→11→10→00 counts up. Each such step adds one to the position.
- R3: The reverse sequence 00→10→11→01→00 counts down. Each such step subtracts one from the position.
- R4: A change of both channels between two filtered samples is ignored: no event pulse, no wrap pulse, no position change. Decoding continues from the new state.
- R5: Every legal step produces an event pulse exactly one clock wide, in the same clock that the position takes its new value.
- R6: The direction output is 1 for an up step and 0 for a down step. It holds the value of a step from at least one clock before that step's event pulse through the end of the pulse.
- R7: The wrap pulse is one clock wide and comes only together with an event pulse. It fires on an up step from the all-ones value to 0 and on a down step from 0 to the all-ones value of the counting width.
- R8: Parameter ACT_W sets the counting width (16 or 12). Output bits at and above ACT_W read as zero at all times.
- R9: While the reset input is low, the position, event pulse and wrap pulse are 0 immediately, without a clock edge. The channels are taken as state 00 when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_a_i | input | 1 | Encoder channel A, asynchronous |
| chan_b_i | input | 1 | Encoder channel B, asynchronous |
| pos_o | output | OUT_W | Position, zero-extended from ACT_W bits |
| cnt_pulse_o | output | 1 | One-clock pulse per legal step |
| dir_up_o | output | 1 | 1 = counting up, 0 = counting down |
| wrap_pulse_o | output | 1 | One-clock pulse on overflow or underflow |

## Verification
The bench builds the block with OUT_W = 16 and ACT_W = 12, which exercises the narrow variant. With these values, a single down step from reset reaches underflow to 0xFFF with the top four bits zero. A single up step then brings overflow back to 0, so both wrap directions take only a few hundred cycles. SYNC_STAGES stays at 2. The bench allows enough cycles per step that the synchroniser, the filter and the single-clock glitch case each finish well inside the wait between steps.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_BAD  = 2'd2,
    MV_DOWN = 2'd3
  } qdec_move_e;

  // Map {A,B} onto a position around the cycle 00,01,11,10.
  function automatic logic [1:0] phase_index(input logic [1:0] ab);
    logic [1:0] idx;
    case (ab)
      2'b00:   idx = 2'd0;
      2'b01:   idx = 2'd1;
      2'b11:   idx = 2'd2;
      default: idx = 2'd3;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/qdec_rst_sync.sv
module qdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_chan_filter.sv
module qdec_chan_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic sync_s;
  logic prev_q;
  logic clean_q, clean_d;

  assign sync_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    clean_d = clean_q;
    if (sync_s == prev_q) clean_d = sync_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      clean_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
      prev_q  <= sync_s;
      clean_q <= clean_d;
    end
  end

  assign clean_o = clean_q;

  // R1
  filter_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_q != $past(clean_q)) |-> ($past(sync_s, 1) == $past(sync_s, 2)));
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic step_o,
  output logic dir_up_o
);
  logic [1:0] prev_q, cur_s;
  logic       step_q, step_d;
  logic       dir_q, dir_d;
  qdec_move_e move_s;

  assign cur_s = {a_i, b_i};

  always_comb begin
    move_s = qdec_move_e'(phase_index(cur_s) - phase_index(prev_q));
    step_d = (move_s == MV_UP) || (move_s == MV_DOWN);
    dir_d  = dir_q;
    if (step_d) dir_d = (move_s == MV_UP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 2'b00;
      step_q <= 1'b0;
      dir_q  <= 1'b1;
    end else begin
      prev_q <= cur_s;
      step_q <= step_d;
      dir_q  <= dir_d;
    end
  end

  assign step_o   = step_q;
  assign dir_up_o = dir_q;

  // R5
  step_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |=> !step_q);
  // R4
  jump_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != $past(a_i) && b_i != $past(b_i)) |=> !step_q);
endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter #(
  parameter int ACT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_up_i,
  output logic [ACT_W-1:0] pos_o,
  output logic             evt_o,
  output logic             wrap_o
);
  logic [ACT_W-1:0] pos_q, pos_d;
  logic             evt_q, evt_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    pos_d  = pos_q;
    evt_d  = step_i;
    wrap_d = 1'b0;
    if (step_i) begin
      if (dir_up_i) begin
        pos_d  = pos_q + 1'b1;
        wrap_d = &pos_q;
      end else begin
        pos_d  = pos_q - 1'b1;
        wrap_d = (pos_q == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      evt_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      evt_q  <= evt_d;
      wrap_q <= wrap_d;
    end
  end

  assign pos_o  = pos_q;
  assign evt_o  = evt_q;
  assign wrap_o = wrap_q;

  // R7
  wrap_with_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> evt_q);
  // R7
  wrap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> (dir_up_i ? (pos_q == '0) : (&pos_q)));
  // R6
  dir_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (dir_up_i == $past(dir_up_i)));
  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && dir_up_i) |-> (pos_q == ACT_W'($past(pos_q) + 1'b1)));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_q |-> (pos_q == $past(pos_q)));
endmodule

// File: rtl/qdec_top.sv
module qdec_top #(
  parameter int OUT_W       = 16,
  parameter int ACT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_a_i,
  input  logic             chan_b_i,
  output logic [OUT_W-1:0] pos_o,
  output logic             cnt_pulse_o,
  output logic             dir_up_o,
  output logic             wrap_pulse_o
);
  localparam int NCH = 2;

  logic             rst_n_s;
  logic [NCH-1:0]   raw_s, clean_s;
  logic             step_s, dir_s;
  logic [ACT_W-1:0] pos_s;

  assign raw_s = {chan_a_i, chan_b_i};

  qdec_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .arst_ni(rst_ni), .rst_no(rst_n_s)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    qdec_chan_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_n_s), .raw_i(raw_s[ch]), .clean_o(clean_s[ch])
    );
  end

  qdec_step_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_n_s), .a_i(clean_s[1]), .b_i(clean_s[0]),
    .step_o(step_s), .dir_up_o(dir_s)
  );

  qdec_pos_counter #(.ACT_W(ACT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n_s), .step_i(step_s), .dir_up_i(dir_s),
    .pos_o(pos_s), .evt_o(cnt_pulse_o), .wrap_o(wrap_pulse_o)
  );

  if (ACT_W < OUT_W) begin : g_pad
    assign pos_o = {{(OUT_W-ACT_W){1'b0}}, pos_s};
  end else begin : g_full
    assign pos_o = pos_s[OUT_W-1:0];
  end

  assign dir_up_o = dir_s;
endmodule

// File: tb/qdec_top_tb.sv
`timescale 1ns/1ps
module qdec_top_tb;
  localparam int OUT_W = 16;
  localparam int ACT_W = 12;
  localparam logic [OUT_W-1:0] TOPV = OUT_W'((1 << ACT_W) - 1);

  typedef struct packed {
    logic             dir;
    logic [OUT_W-1:0] pos;
    logic             wrap;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_a = 1'b0, ch_b = 1'b0;
  logic [OUT_W-1:0] pos;
  logic cnt_p, dir_up, wrap_p;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t sb_q[$];
  logic [OUT_W-1:0] exp_pos = '0;
  logic [1:0] cur_ab = 2'b00;
  logic dir_prev = 1'b1, cnt_prev = 1'b0;

  always #2.5 clk = ~clk;

  qdec_top #(.OUT_W(OUT_W), .ACT_W(ACT_W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_a_i(ch_a), .chan_b_i(ch_b),
    .pos_o(pos), .cnt_pulse_o(cnt_p), .dir_up_o(dir_up), .wrap_pulse_o(wrap_p)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] up_of(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] down_of(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic step(input bit up);
    exp_t e;
    logic [1:0] nxt;
    nxt = up ? up_of(cur_ab) : down_of(cur_ab);
    e.dir  = up;
    e.wrap = up ? (exp_pos == TOPV) : (exp_pos == '0);
    exp_pos = up ? ((exp_pos == TOPV) ? '0 : exp_pos + 1'b1)
                 : ((exp_pos == '0) ? TOPV : exp_pos - 1'b1);
    e.pos = exp_pos;
    sb_q.push_back(e);
    @(negedge clk);
    {ch_a, ch_b} = nxt;
    cur_ab = nxt;
    settle();
  endtask

  // Monitor: pops the scoreboard on each event pulse.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pos[OUT_W-1:ACT_W] != '0)
        chk(0, "R8 upper bits", 32'(pos), 32'(pos[ACT_W-1:0]));
      if (wrap_p && !cnt_p) chk(0, "R7 wrap without event", 32'(wrap_p), 0);
      if (cnt_p && cnt_prev) chk(0, "R5 pulse wider than one clock", 2, 1);
      if (cnt_p) begin
        if (sb_q.size() == 0) chk(0, "R4/R5 unexpected event pulse", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(pos == e.pos, e.dir ? "R2 position up" : "R3 position down", 32'(pos), 32'(e.pos));
          chk(dir_up == e.dir && dir_prev == e.dir, "R6 direction settled", {dir_prev, dir_up}, {e.dir, e.dir});
          chk(wrap_p == e.wrap, "R7 wrap pulse", 32'(wrap_p), 32'(e.wrap));
        end
      end
    end
    dir_prev = dir_up;
    cnt_prev = cnt_p;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pos == 0 && !cnt_p && !wrap_p, "R9 reset state", 32'({pos, cnt_p, wrap_p}), 0);
    @(negedge clk); rst_n = 1'b1;
    settle();
    chk(pos == 0 && !cnt_p, "R9 idle after release", 32'(pos), 0);

    // Underflow then overflow in the narrow variant (R7, R8)
    step(0);
    chk(pos == 16'h0FFF, "R7 R8 underflow value", 32'(pos), 32'h0FFF);
    step(1);
    chk(pos == 16'h0000, "R7 overflow value", 32'(pos), 0);

    // R2: a full cycle up plus more
    for (int i = 0; i < 9; i++) step(1);
    chk(pos == exp_pos, "R2 after up run", 32'(pos), 32'(exp_pos));

    // R3: down steps
    for (int i = 0; i < 3; i++) step(0);
    chk(pos == exp_pos, "R3 after down run", 32'(pos), 32'(exp_pos));

    // R1: single-clock glitch on B
    @(negedge clk); ch_b = ~ch_b;
    @(negedge clk); ch_b = ~ch_b;
    settle();
    chk(pos == exp_pos && !cnt_p, "R1 glitch ignored", 32'(pos), 32'(exp_pos));

    // R4: double-bit jump
    @(negedge clk); {ch_a, ch_b} = ~cur_ab; cur_ab = ~cur_ab;
    settle();
    chk(pos == exp_pos, "R4 jump ignored", 32'(pos), 32'(exp_pos));
    step(1);
    step(0);
    step(0);
    chk(pos == exp_pos, "R4 decode resumes", 32'(pos), 32'(exp_pos));

    // Return to state 00, then reset mid-run (R9)
    while (cur_ab != 2'b00) step(1);
    chk(pos != 0, "R9 nonzero before reset", 32'(pos), 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(pos == 0 && !cnt_p && !wrap_p, "R9 asynchronous clear", 32'(pos), 0);
    exp_pos = '0;
    @(negedge clk); rst_n = 1'b1;
    settle();
    step(1);
    step(1);
    chk(pos == 16'd2, "R2 count after reset", 32'(pos), 2);

    chk(sb_q.size() == 0, "R5 every step pulsed", sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule